// File: doc/BRIEF.md
# I2C Transfer Phase and Status Tracker

This block follows one I2C controller through a transfer and reports where it is. It publishes a 3-bit phase code and five status flags: bus busy, master role, transmitter role, bus held and NACK seen. It does not generate any bit timing. It watches the already-synchronized SCL and SDA lines to find START and STOP conditions on the bus. It also reacts to one-cycle strobes from the byte engine that report the end of each phase. A software continue strobe releases the bus after the block has stopped at an acknowledge phase.

When a master transfer is requested, the block waits until the bus is free, then steps through START, address, address acknowledge, data and data acknowledge. After every acknowledge phase it holds the bus so that software can decide how to go on. While the bus is held, the phase code stays frozen and a NACK received in that acknowledge phase is visible. When slave operation is enabled, a START seen on the bus while the block is idle takes it straight to the address phase as a slave.

Top module: `i2c_xfer_tracker`

## Requirements
- R1: After reset the phase code is IDLE and every flag is 0. The phase codes are IDLE=0, WAIT=1, START=2, ADDR=3, ADDRACK=4, DATA=5, DATAACK=6.
- R2: BUSY sets on the clock edge that first samples SDA falling while SCL is high on this and the previous sample. It clears on the edge that first samples SDA rising under the same SCL condition. Bus activity from any source counts.
- R3: In IDLE, with no slave entry pending, a start request moves the phase to WAIT on the next edge and sets MASTER.
- R4: WAIT moves to START on the first edge at which BUSY reads 0 before that edge. While BUSY reads 1, the phase stays in WAIT.
- R5: The phases advance in order when not held. START goes to ADDR on start-done. ADDR goes to ADDRACK on address-done. DATA goes to DATAACK on data-done.
- R6: An ack-done strobe in ADDRACK or DATAACK sets BUSHOLD. While BUSHOLD is 1, the phase stays constant and every byte-engine strobe has no effect.
- R7: A continue strobe clears BUSHOLD on the next edge. A continue strobe while BUSHOLD is 0 has no effect.
- R8: At ack-done, the block captures the NACK indication. The NACK output reads 1 only while BUSHOLD is 1 in ADDRACK or DATAACK and the captured indication is 1. It clears on release.
- R9: In an acknowledge phase that is not held, the strobes are served in priority order: stop-done goes to IDLE, then repeated-start goes to START, then next-byte goes to DATA. Stop-done also ends any unheld phase from START to DATAACK.
- R10: MASTER is 1 from the accepted start request until the phase returns to IDLE. It is 0 in every slave transfer.
- R11: TRANSMITTER is 0 in IDLE and WAIT. On entry to START it is set to 1. On slave entry it is set to 0. At the address ack-done it takes the direction input, where 1 means this side sends data.
- R12: With slave enable at 1, a bus START in IDLE moves the phase to ADDR with MASTER at 0. A bus STOP during an unheld slave transfer returns the phase to IDLE. With slave enable at 0, a bus START leaves the phase in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| slave_en | input | 1 | Allow being addressed as a slave |
| start_req | input | 1 | Strobe: request a master transfer |
| start_done | input | 1 | Strobe: START condition sent |
| addr_done | input | 1 | Strobe: address byte finished |
| ack_done | input | 1 | Strobe: acknowledge bit finished |
| ack_nack | input | 1 | NACK indication, valid with ack_done |
| dir_tx | input | 1 | Data direction, valid with the address ack_done (1 = send) |
| data_done | input | 1 | Strobe: data byte finished |
| next_byte | input | 1 | Strobe: next data byte begins |
| rep_start | input | 1 | Strobe: repeated START begins |
| stop_done | input | 1 | Strobe: STOP finished |
| sw_continue | input | 1 | Strobe from software: release the hold |
| state_o | output | 3 | Phase code |
| busy_o | output | 1 | Bus busy |
| master_o | output | 1 | Operating as master |
| tx_o | output | 1 | Operating as transmitter |
| bushold_o | output | 1 | Bus held, awaiting software |
| nack_o | output | 1 | NACK received in the held acknowledge phase |

## Verification
The hardest case to reach is WAIT while another device owns the bus. The request has to land while BUSY is already 1, and the bench must then show the single cycle in which BUSY has dropped but the phase still reads WAIT. The stimulus first drives a START onto SDA, then issues the request, lets one cycle pass, and then raises SDA for a STOP. A related hard case is a bus STOP arriving while a slave transfer is held. The bench builds that by holding a slave address acknowledge phase and raising SDA before sending continue.

// File: rtl/i2c_trk_pkg.sv
package i2c_trk_pkg;

  localparam int PH_W = 3;

  typedef enum logic [PH_W-1:0] {
    PH_IDLE    = 3'd0,
    PH_WAIT    = 3'd1,
    PH_START   = 3'd2,
    PH_ADDR    = 3'd3,
    PH_ADDRACK = 3'd4,
    PH_DATA    = 3'd5,
    PH_DATAACK = 3'd6
  } phase_t;

  // Acknowledge phases: the only places a hold can be taken
  function automatic logic is_ack(input phase_t p);
    return (p == PH_ADDRACK) || (p == PH_DATAACK);
  endfunction

  // Phases that belong to an ongoing transfer on the wire
  function automatic logic in_xfer(input phase_t p);
    return (p >= PH_START) && (p <= PH_DATAACK);
  endfunction

  // Choice after a released acknowledge phase: stop, then restart, then next byte
  function automatic phase_t after_ack(input logic stp, input logic rsta,
                                       input logic nxt, input phase_t cur);
    if (stp)       return PH_IDLE;
    else if (rsta) return PH_START;
    else if (nxt)  return PH_DATA;
    else           return cur;
  endfunction

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_det,
  output logic stop_det,
  output logic busy
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SCL stable high across the two samples, SDA changes
  assign start_det = scl_i & scl_q &  sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q &  sda_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy <= 1'b0;
    else if (start_det) busy <= 1'b1;
    else if (stop_det)  busy <= 1'b0;
  end
endmodule

// File: rtl/i2c_phase_seq.sv
module i2c_phase_seq
  import i2c_trk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   busy,
  input  logic   start_det,
  input  logic   stop_det,
  input  logic   master,
  input  logic   slave_en,
  input  logic   start_req,
  input  logic   start_done,
  input  logic   addr_done,
  input  logic   ack_done,
  input  logic   ack_nack,
  input  logic   data_done,
  input  logic   next_byte,
  input  logic   rep_start,
  input  logic   stop_done,
  input  logic   sw_continue,
  output phase_t phase,
  output logic   hold,
  output logic   nack_cap,
  output logic   ev_req,
  output logic   ev_slave,
  output logic   ev_start,
  output logic   ev_addr_ack,
  output logic   ev_idle
);
  phase_t nxt;
  logic   hold_n, nack_n;

  always_comb begin
    nxt         = phase;
    hold_n      = hold;
    nack_n      = nack_cap;
    ev_req      = 1'b0;
    ev_slave    = 1'b0;
    ev_addr_ack = 1'b0;
    if (hold) begin
      if (sw_continue) begin
        hold_n = 1'b0;
        nack_n = 1'b0;
      end
    end else if (in_xfer(phase) && (stop_done || (!master && stop_det))) begin
      nxt = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (slave_en && start_det) begin
            nxt      = PH_ADDR;
            ev_slave = 1'b1;
          end else if (start_req) begin
            nxt    = PH_WAIT;
            ev_req = 1'b1;
          end
        end
        PH_WAIT:  if (!busy)      nxt = PH_START;
        PH_START: if (start_done) nxt = PH_ADDR;
        PH_ADDR:  if (addr_done)  nxt = PH_ADDRACK;
        PH_DATA:  if (data_done)  nxt = PH_DATAACK;
        PH_ADDRACK, PH_DATAACK: begin
          if (ack_done) begin
            hold_n      = 1'b1;
            nack_n      = ack_nack;
            ev_addr_ack = (phase == PH_ADDRACK);
          end else begin
            nxt = after_ack(stop_done, rep_start, next_byte, phase);
          end
        end
        default: nxt = PH_IDLE;
      endcase
    end
  end

  assign ev_start = (nxt == PH_START) && (phase != PH_START);
  assign ev_idle  = (nxt == PH_IDLE)  && (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      hold     <= 1'b0;
      nack_cap <= 1'b0;
    end else begin
      phase    <= nxt;
      hold     <= hold_n;
      nack_cap <= nack_n;
    end
  end
endmodule

// File: rtl/i2c_role_flags.sv
module i2c_role_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_req,
  input  logic ev_slave,
  input  logic ev_start,
  input  logic ev_addr_ack,
  input  logic ev_idle,
  input  logic dir_tx,
  output logic master,
  output logic tx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master <= 1'b0;
      tx     <= 1'b0;
    end else begin
      if (ev_idle || ev_slave) master <= 1'b0;
      else if (ev_req)         master <= 1'b1;

      if (ev_idle || ev_slave) tx <= 1'b0;
      else if (ev_start)       tx <= 1'b1;
      else if (ev_addr_ack)    tx <= dir_tx;
    end
  end
endmodule

// File: rtl/i2c_xfer_tracker.sv
module i2c_xfer_tracker
  import i2c_trk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            slave_en,
  input  logic            start_req,
  input  logic            start_done,
  input  logic            addr_done,
  input  logic            ack_done,
  input  logic            ack_nack,
  input  logic            dir_tx,
  input  logic            data_done,
  input  logic            next_byte,
  input  logic            rep_start,
  input  logic            stop_done,
  input  logic            sw_continue,
  output logic [PH_W-1:0] state_o,
  output logic            busy_o,
  output logic            master_o,
  output logic            tx_o,
  output logic            bushold_o,
  output logic            nack_o
);
  logic   start_det, stop_det, busy, master, tx, hold, nack_cap;
  logic   ev_req, ev_slave, ev_start, ev_addr_ack, ev_idle;
  phase_t phase;

  i2c_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .start_det(start_det), .stop_det(stop_det), .busy(busy)
  );

  i2c_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start_det(start_det),
    .stop_det(stop_det), .master(master), .slave_en(slave_en),
    .start_req(start_req), .start_done(start_done), .addr_done(addr_done),
    .ack_done(ack_done), .ack_nack(ack_nack), .data_done(data_done),
    .next_byte(next_byte), .rep_start(rep_start), .stop_done(stop_done),
    .sw_continue(sw_continue), .phase(phase), .hold(hold),
    .nack_cap(nack_cap), .ev_req(ev_req), .ev_slave(ev_slave),
    .ev_start(ev_start), .ev_addr_ack(ev_addr_ack), .ev_idle(ev_idle)
  );

  i2c_role_flags u_role (
    .clk(clk), .rst_n(rst_n), .ev_req(ev_req), .ev_slave(ev_slave),
    .ev_start(ev_start), .ev_addr_ack(ev_addr_ack), .ev_idle(ev_idle),
    .dir_tx(dir_tx), .master(master), .tx(tx)
  );

  assign state_o   = phase;
  assign busy_o    = busy;
  assign master_o  = master;
  assign tx_o      = tx;
  assign bushold_o = hold;
  assign nack_o    = hold & is_ack(phase) & nack_cap;
endmodule

// File: rtl/i2c_xfer_tracker_chk.sv
module i2c_xfer_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_det,
  input logic       stop_det,
  input logic       slave_en,
  input logic       sw_continue,
  input logic [2:0] state_o,
  input logic       busy_o,
  input logic       master_o,
  input logic       bushold_o,
  input logic       nack_o
);
  assert_code_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd6);

  assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy_o);

  assert_busy_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !busy_o);

  assert_wait_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && !busy_o) |=> state_o == 3'd2);

  assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bushold_o && !sw_continue) |=> (bushold_o && $stable(state_o)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bushold_o && sw_continue) |=> !bushold_o);

  assert_nack_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nack_o |-> (bushold_o && (state_o == 3'd4 || state_o == 3'd6)));

  assert_idle_no_master_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0) |-> !master_o);

  assert_slave_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && slave_en && start_det) |=> (state_o == 3'd3 && !master_o));
endmodule

bind i2c_xfer_tracker i2c_xfer_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
  .slave_en(slave_en), .sw_continue(sw_continue), .state_o(state_o),
  .busy_o(busy_o), .master_o(master_o), .bushold_o(bushold_o), .nack_o(nack_o)
);

// File: tb/test_i2c_xfer_tracker.sv
module test_i2c_xfer_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, slv = 1'b0;
  logic s_req, s_sd, s_ad, s_ack, s_nk, s_dir, s_dd, s_nb, s_rs, s_stp, s_cont;
  logic [2:0] st;
  logic busy, mst, tx, hold, nack;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_xfer_tracker i_i2c_xfer_tracker (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .slave_en(slv),
    .start_req(s_req), .start_done(s_sd), .addr_done(s_ad), .ack_done(s_ack),
    .ack_nack(s_nk), .dir_tx(s_dir), .data_done(s_dd), .next_byte(s_nb),
    .rep_start(s_rs), .stop_done(s_stp), .sw_continue(s_cont),
    .state_o(st), .busy_o(busy), .master_o(mst), .tx_o(tx),
    .bushold_o(hold), .nack_o(nack)
  );

  // {phase, busy, master, transmitter, hold, nack}
  function automatic logic [7:0] pk(input int p, input bit b, input bit m,
                                    input bit t, input bit h, input bit n);
    return {p[2:0], b, m, t, h, n};
  endfunction

  task automatic clr();
    {s_req, s_sd, s_ad, s_ack, s_nk, s_dir, s_dd, s_nb, s_rs, s_stp, s_cont} = '0;
  endtask

  // Driver: strobes already set; let one edge pass, then queue the expectation
  task automatic tick(input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    clr();
    it.exp = e;
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = q.pop_front();
      act = {st, busy, mst, tx, hold, nack};
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got st=%0d b/m/t/h/n=%b expected st=%0d b/m/t/h/n=%b",
                 it.tag, act[7:5], act[4:0], it.exp[7:5], it.exp[4:0]);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_fail++;
        n_run++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick(pk(0,0,0,0,0,0), "R1 reset state");

    // Master write to completion
    s_req = 1;                       tick(pk(1,0,1,0,0,0), "R3 request to WAIT");
                                     tick(pk(2,0,1,1,0,0), "R4 R11 idle bus to START");
    sda = 0;                         tick(pk(2,1,1,1,0,0), "R2 busy on START");
    s_sd = 1;                        tick(pk(3,1,1,1,0,0), "R5 ADDR");
    s_ad = 1;                        tick(pk(4,1,1,1,0,0), "R5 ADDRACK");
    s_ack = 1; s_dir = 1;            tick(pk(4,1,1,1,1,0), "R6 R11 hold at address ack");
    s_nb = 1; s_dd = 1; s_stp = 1;   tick(pk(4,1,1,1,1,0), "R6 strobes ignored while held");
                                     tick(pk(4,1,1,1,1,0), "R6 hold persists");
    s_cont = 1;                      tick(pk(4,1,1,1,0,0), "R7 release");
    s_cont = 1;                      tick(pk(4,1,1,1,0,0), "R7 continue ignored unheld");
    s_nb = 1;                        tick(pk(5,1,1,1,0,0), "R9 next byte to DATA");
    s_dd = 1;                        tick(pk(6,1,1,1,0,0), "R5 DATAACK");
    s_ack = 1; s_nk = 1;             tick(pk(6,1,1,1,1,1), "R8 NACK visible held");
    s_cont = 1;                      tick(pk(6,1,1,1,0,0), "R8 NACK cleared on release");
    s_rs = 1; s_nb = 1;              tick(pk(2,1,1,1,0,0), "R9 restart beats next byte");
    s_sd = 1;                        tick(pk(3,1,1,1,0,0), "R5 ADDR again");
    s_ad = 1;                        tick(pk(4,1,1,1,0,0), "R5 ADDRACK again");
    s_ack = 1; s_dir = 0; s_nk = 1;  tick(pk(4,1,1,0,1,1), "R8 R11 address NACK, receive");
    s_cont = 1;                      tick(pk(4,1,1,0,0,0), "R8 cleared");
    s_nb = 1;                        tick(pk(5,1,1,0,0,0), "R11 DATA as receiver");
    s_dd = 1;                        tick(pk(6,1,1,0,0,0), "R5 DATAACK");
    s_ack = 1;                       tick(pk(6,1,1,0,1,0), "R8 ACK held, NACK 0");
    s_cont = 1;                      tick(pk(6,1,1,0,0,0), "R7 release");
    s_stp = 1; s_rs = 1; s_nb = 1;   tick(pk(0,1,0,0,0,0), "R9 R10 stop wins, to IDLE");
    sda = 1;                         tick(pk(0,0,0,0,0,0), "R2 busy clears on STOP");

    // Request while another master owns the bus
    sda = 0;                         tick(pk(0,1,0,0,0,0), "R2 foreign START");
    s_req = 1;                       tick(pk(1,1,1,0,0,0), "R3 WAIT on busy bus");
                                     tick(pk(1,1,1,0,0,0), "R4 stay in WAIT");
    sda = 1;                         tick(pk(1,0,1,0,0,0), "R4 busy drops, still WAIT");
                                     tick(pk(2,0,1,1,0,0), "R4 START after idle");
    s_stp = 1;                       tick(pk(0,0,0,0,0,0), "R9 R10 abort from START");

    // Slave operation
    sda = 0;                         tick(pk(0,1,0,0,0,0), "R12 slave disabled stays IDLE");
    sda = 1;                         tick(pk(0,0,0,0,0,0), "R2 STOP");
    slv = 1; sda = 0;                tick(pk(3,1,0,0,0,0), "R12 slave entry to ADDR");
    s_ad = 1;                        tick(pk(4,1,0,0,0,0), "R12 slave ADDRACK");
    s_ack = 1; s_dir = 1;            tick(pk(4,1,0,1,1,0), "R11 slave transmitter held");
    sda = 1;                         tick(pk(4,0,0,1,1,0), "R12 bus STOP ignored while held");
    s_cont = 1;                      tick(pk(4,0,0,1,0,0), "R7 release");
    s_nb = 1;                        tick(pk(5,0,0,1,0,0), "R9 slave DATA");
    sda = 0;                         tick(pk(5,1,0,1,0,0), "R2 START during slave DATA");
    sda = 1;                         tick(pk(0,0,0,0,0,0), "R12 bus STOP ends slave transfer");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule